// File: doc/BRIEF.md
# USB Device Link State Tracker

This block follows the condition of a USB device's link from a handful of already-decoded observations. The inputs are the bus power sense pin, an optional power-sense override, and three line conditions from the receiver: single-ended zero, idle J and a one-cycle activity strobe. It also takes a strobe for each valid start-of-frame together with that frame's 11-bit number. It keeps a six-valued link state, the most recent frame number, a host-lost flag and the 7-bit device address that software programs. It raises one-cycle event pulses for connect, disconnect, link reset, suspend, resume, frame and host-lost.

All three durations are counted in ticks of a one-microsecond strobe `tick_us`, and each has its own parameter. A bus reset needs SE0 held for `SE0_TICKS` ticks. A suspend needs idle J held for `IDLE_TICKS` ticks. The host is declared lost after `SOF_TICKS` ticks in the active state with no start-of-frame. The defaults are 3, 3000 and 4096. The line decoder, packet parsing, the register interface and clock-domain crossing all live outside this block. Every input is assumed synchronous to `clk`.

Top module: `usb_link_tracker`

## Requirements
- R1: `link_state` uses the encoding 0 disconnected, 1 powered and not yet reset, 2 suspended while unreset, 3 active, 4 suspended after being active, 5 active with no start-of-frame since the last reset. No other value ever appears. After reset the state is 0, `frame_num`, `host_lost` and `dev_addr` are zero, and no event is pulsing.
- R2: In state 0, effective power present moves the state to 1 at the next clock edge and pulses `ev_connect` in the same cycle as the new state.
- R3: In any state other than 0, effective power absent moves the state to 0 at the next edge and pulses `ev_disconnect`.
- R4: While `pwr_ovr_en` is 1, `pwr_ovr_val` replaces `vbus_sense` as the effective power. `sense_raw` always shows the pin itself.
- R5: SE0 held while `SE0_TICKS` ticks arrive is a bus reset. On the edge that samples the last of those ticks, the state becomes 5 from any powered state and `ev_link_reset` pulses. The event fires once per SE0 episode, however long SE0 lasts.
- R6: Idle J held while `IDLE_TICKS` ticks arrive is a suspend: state 1 goes to 2, and states 3 and 5 go to 4, each with one `ev_suspend` pulse. An activity strobe or a start-of-frame restarts the idle count.
- R7: In state 4, activity (or a start-of-frame) returns the link to 3 and pulses `ev_resume`. In state 2, activity returns the link to 1 without any event.
- R8: An accepted start-of-frame (any state but 0) copies `sof_frame` into `frame_num` and pulses `ev_frame` at the next edge, and it moves state 5 to 3.
- R9: In state 3, `SOF_TICKS` ticks without a start-of-frame set `host_lost` and pulse `ev_host_lost` once. A start-of-frame clears the flag and restarts the count. A bus reset or a disconnect also clears the flag.
- R10: A start-of-frame in the same cycle as the tick that would complete the host-lost count wins: no `ev_host_lost` is raised and `host_lost` stays 0.
- R11: `addr_wr` loads `addr_wdata` into `dev_addr`. A bus reset zeroes `dev_addr`, and this takes priority over a write in the same cycle.
- R12: A power loss in the same cycle as a completed SE0 count gives only the disconnect: state 0, `ev_disconnect` alone, and `dev_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| vbus_sense | input | 1 | Bus power sense pin |
| pwr_ovr_en | input | 1 | Selects the override value as effective power |
| pwr_ovr_val | input | 1 | Override power value |
| line_se0 | input | 1 | Line currently at single-ended zero |
| line_idle | input | 1 | Line currently at idle J |
| line_activity | input | 1 | One-cycle strobe for any line activity |
| sof_valid | input | 1 | One-cycle strobe for a valid start-of-frame |
| sof_frame | input | 11 | Frame number carried with `sof_valid` |
| addr_wr | input | 1 | Write strobe for the device address |
| addr_wdata | input | 7 | Device address to load |
| sense_raw | output | 1 | Unmodified power sense pin |
| link_state | output | 3 | Encoded link state (R1) |
| frame_num | output | 11 | Last accepted frame number |
| host_lost | output | 1 | Start-of-frame missing too long in state 3 |
| dev_addr | output | 7 | Current device address |
| ev_connect | output | 1 | Connect event pulse |
| ev_disconnect | output | 1 | Disconnect event pulse |
| ev_link_reset | output | 1 | Bus reset event pulse |
| ev_suspend | output | 1 | Suspend event pulse |
| ev_resume | output | 1 | Resume event pulse |
| ev_frame | output | 1 | Frame event pulse |
| ev_host_lost | output | 1 | Host-lost event pulse |

## Verification
The collision of interest is a start-of-frame arriving in the very cycle whose tick would complete the missing-frame count. The bench runs the host-lost counter to one tick short of its limit. It then drives that final tick and `sof_valid` in one cycle. The scoreboard expects exactly one frame event with `host_lost` low, and it counts any host-lost pulse as an unexpected item. The same single-cycle method is used on two other pairs: a completed SE0 count against a power drop, and against an address write. In each case the exact event vector, state and address are compared at the cycle after the shared edge.

// File: rtl/usb_link_pkg.sv
package usb_link_pkg;

    localparam int FRAME_W = 11;
    localparam int ADDR_W  = 7;

    typedef enum logic [2:0] {
        LS_DISC         = 3'd0,
        LS_POWERED      = 3'd1,
        LS_PWR_SUSP     = 3'd2,
        LS_ACTIVE       = 3'd3,
        LS_SUSP         = 3'd4,
        LS_ACTIVE_NOSOF = 3'd5
    } link_state_e;

    typedef struct packed {
        logic connect;
        logic disconnect;
        logic bus_reset;
        logic suspend;
        logic resume;
        logic frame;
        logic host_lost;
    } link_ev_t;

    // Suspended state reached from a given awake state.
    function automatic link_state_e suspend_target(link_state_e s);
        return (s == LS_POWERED) ? LS_PWR_SUSP : LS_SUSP;
    endfunction

    // States in which a long idle period counts as a suspend.
    function automatic logic may_suspend(link_state_e s);
        return (s == LS_POWERED) || (s == LS_ACTIVE) || (s == LS_ACTIVE_NOSOF);
    endfunction

endpackage

// File: rtl/link_tick_timer.sv
// Saturating microsecond-tick counter: one hit per uninterrupted run.
module link_tick_timer #(
    parameter int unsigned LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic run_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_o = run_i && tick_i && (cnt_q == LAST);

    // Shared by R5, R6 and R9: the count never passes its limit.
    a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP);

    // R6/R9: once the limit is reached, a continued run never hits again.
    a_r6_no_rehit: assert property (@(posedge clk) disable iff (rst)
        (run_i && cnt_q == TOP) |-> !hit_o);

endmodule

// File: rtl/link_state_fsm.sv
module link_state_fsm
    import usb_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_i,
    input  logic        se0_hit_i,
    input  logic        idle_hit_i,
    input  logic        nosof_hit_i,
    input  logic        activity_i,
    input  logic        sof_i,
    output link_state_e state_o,
    output link_ev_t    ev_d_o,
    output link_ev_t    ev_q_o
);
    link_state_e state_q, state_d;
    link_ev_t    ev_d, ev_q;

    always_comb begin
        state_d = state_q;
        ev_d    = '0;
        if (state_q == LS_DISC) begin
            if (pwr_i) begin
                state_d    = LS_POWERED;
                ev_d.connect = 1'b1;
            end
        end else if (!pwr_i) begin
            state_d         = LS_DISC;
            ev_d.disconnect = 1'b1;
        end else if (se0_hit_i) begin
            state_d        = LS_ACTIVE_NOSOF;
            ev_d.bus_reset = 1'b1;
            ev_d.frame     = sof_i;
        end else begin
            ev_d.frame = sof_i;
            if (idle_hit_i && may_suspend(state_q)) begin
                state_d      = suspend_target(state_q);
                ev_d.suspend = 1'b1;
            end else begin
                unique case (state_q)
                    LS_PWR_SUSP: begin
                        if (activity_i || sof_i) state_d = LS_POWERED;
                    end
                    LS_SUSP: begin
                        if (activity_i || sof_i) begin
                            state_d     = LS_ACTIVE;
                            ev_d.resume = 1'b1;
                        end
                    end
                    LS_ACTIVE_NOSOF: begin
                        if (sof_i) state_d = LS_ACTIVE;
                    end
                    LS_ACTIVE: begin
                        if (nosof_hit_i) ev_d.host_lost = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_DISC;
            ev_q    <= '0;
        end else begin
            state_q <= state_d;
            ev_q    <= ev_d;
        end
    end

    assign state_o = state_q;
    assign ev_d_o  = ev_d;
    assign ev_q_o  = ev_q;

    a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
        state_q inside {LS_DISC, LS_POWERED, LS_PWR_SUSP, LS_ACTIVE, LS_SUSP, LS_ACTIVE_NOSOF});

    a_r2_connect_lands_powered: assert property (@(posedge clk) disable iff (rst)
        ev_q.connect |-> state_q == LS_POWERED);

    a_r3_power_loss: assert property (@(posedge clk) disable iff (rst)
        !pwr_i |=> state_q == LS_DISC);

    a_r5_reset_enters_nosof: assert property (@(posedge clk) disable iff (rst)
        ev_q.bus_reset |-> state_q == LS_ACTIVE_NOSOF);

    a_r6_suspend_target: assert property (@(posedge clk) disable iff (rst)
        ev_q.suspend |-> (state_q == LS_PWR_SUSP || state_q == LS_SUSP));

    a_r7_resume_from_susp: assert property (@(posedge clk) disable iff (rst)
        ev_q.resume |-> (state_q == LS_ACTIVE && $past(state_q) == LS_SUSP));

    a_r12_link_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_q.connect, ev_q.disconnect, ev_q.bus_reset}));

endmodule

// File: rtl/link_status_regs.sv
module link_status_regs
    import usb_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  link_ev_t           ev_d_i,
    input  logic [FRAME_W-1:0] sof_frame_i,
    input  logic               addr_wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               host_lost_o,
    output logic [ADDR_W-1:0]  addr_o
);
    logic [FRAME_W-1:0] frame_q;
    logic               lost_q;
    logic [ADDR_W-1:0]  addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            lost_q  <= 1'b0;
            addr_q  <= '0;
        end else begin
            if (ev_d_i.frame) frame_q <= sof_frame_i;

            if (ev_d_i.host_lost) begin
                lost_q <= 1'b1;
            end else if (ev_d_i.frame || ev_d_i.bus_reset || ev_d_i.disconnect) begin
                lost_q <= 1'b0;
            end

            if (ev_d_i.bus_reset) begin
                addr_q <= '0;
            end else if (addr_wr_i) begin
                addr_q <= addr_i;
            end
        end
    end

    assign frame_o     = frame_q;
    assign host_lost_o = lost_q;
    assign addr_o      = addr_q;

    a_r11_write_loads: assert property (@(posedge clk) disable iff (rst)
        (addr_wr_i && !ev_d_i.bus_reset) |=> addr_q == $past(addr_i));

    a_r9_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (lost_q && !ev_d_i.frame && !ev_d_i.bus_reset && !ev_d_i.disconnect) |=> lost_q);

endmodule

// File: rtl/usb_link_tracker.sv
module usb_link_tracker
    import usb_link_pkg::*;
#(
    parameter int unsigned SE0_TICKS  = 3,
    parameter int unsigned IDLE_TICKS = 3000,
    parameter int unsigned SOF_TICKS  = 4096
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_us,
    input  logic               vbus_sense,
    input  logic               pwr_ovr_en,
    input  logic               pwr_ovr_val,
    input  logic               line_se0,
    input  logic               line_idle,
    input  logic               line_activity,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               addr_wr,
    input  logic [ADDR_W-1:0]  addr_wdata,
    output logic               sense_raw,
    output logic [2:0]         link_state,
    output logic [FRAME_W-1:0] frame_num,
    output logic               host_lost,
    output logic [ADDR_W-1:0]  dev_addr,
    output logic               ev_connect,
    output logic               ev_disconnect,
    output logic               ev_link_reset,
    output logic               ev_suspend,
    output logic               ev_resume,
    output logic               ev_frame,
    output logic               ev_host_lost
);
    logic        pwr_eff;
    logic        se0_hit, idle_hit, nosof_hit;
    link_state_e state;
    link_ev_t    ev_d, ev_q;

    assign pwr_eff   = pwr_ovr_en ? pwr_ovr_val : vbus_sense;
    assign sense_raw = vbus_sense;

    link_tick_timer #(.LIMIT(SE0_TICKS)) u_se0_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_us),
        .run_i  (line_se0),
        .hit_o  (se0_hit)
    );

    link_tick_timer #(.LIMIT(IDLE_TICKS)) u_idle_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_us),
        .run_i  (line_idle && !line_activity && !sof_valid),
        .hit_o  (idle_hit)
    );

    link_tick_timer #(.LIMIT(SOF_TICKS)) u_sof_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_us),
        .run_i  ((state == LS_ACTIVE) && !sof_valid),
        .hit_o  (nosof_hit)
    );

    link_state_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pwr_i       (pwr_eff),
        .se0_hit_i   (se0_hit),
        .idle_hit_i  (idle_hit),
        .nosof_hit_i (nosof_hit),
        .activity_i  (line_activity),
        .sof_i       (sof_valid),
        .state_o     (state),
        .ev_d_o      (ev_d),
        .ev_q_o      (ev_q)
    );

    link_status_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .ev_d_i      (ev_d),
        .sof_frame_i (sof_frame),
        .addr_wr_i   (addr_wr),
        .addr_i      (addr_wdata),
        .frame_o     (frame_num),
        .host_lost_o (host_lost),
        .addr_o      (dev_addr)
    );

    assign link_state    = state;
    assign ev_connect    = ev_q.connect;
    assign ev_disconnect = ev_q.disconnect;
    assign ev_link_reset = ev_q.bus_reset;
    assign ev_suspend    = ev_q.suspend;
    assign ev_resume     = ev_q.resume;
    assign ev_frame      = ev_q.frame;
    assign ev_host_lost  = ev_q.host_lost;

    a_r4_override_off: assert property (@(posedge clk) disable iff (rst)
        (pwr_ovr_en && !pwr_ovr_val) |=> link_state == 3'd0);

    a_r8_frame_capture: assert property (@(posedge clk) disable iff (rst)
        ev_frame |-> frame_num == $past(sof_frame));

    a_r9_flag_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(host_lost) |-> ev_host_lost);

    a_r10_sof_beats_timeout: assert property (@(posedge clk) disable iff (rst)
        sof_valid |=> !ev_host_lost);

    a_r11_reset_clears_addr: assert property (@(posedge clk) disable iff (rst)
        ev_link_reset |-> dev_addr == '0);

endmodule

// File: tb/sim_usb_link_tracker.sv
module sim_usb_link_tracker;

    localparam int SE0_T  = 3;
    localparam int IDLE_T = 12;
    localparam int SOF_T  = 20;

    localparam logic [6:0] E_CON = 7'b1000000;
    localparam logic [6:0] E_DIS = 7'b0100000;
    localparam logic [6:0] E_RST = 7'b0010000;
    localparam logic [6:0] E_SUS = 7'b0001000;
    localparam logic [6:0] E_RES = 7'b0000100;
    localparam logic [6:0] E_FRM = 7'b0000010;
    localparam logic [6:0] E_HL  = 7'b0000001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, vbus = 1'b0, ovr_en = 1'b0, ovr_val = 1'b0;
    logic se0 = 1'b0, idle = 1'b0, act = 1'b0, sof = 1'b0, awr = 1'b0;
    logic [10:0] sof_fr = '0;
    logic [6:0]  awd = '0;

    logic        sense_raw, host_lost;
    logic [2:0]  link_state;
    logic [10:0] frame_num;
    logic [6:0]  dev_addr;
    logic ev_con, ev_dis, ev_rst, ev_sus, ev_res, ev_frm, ev_hl;

    usb_link_tracker #(.SE0_TICKS(SE0_T), .IDLE_TICKS(IDLE_T), .SOF_TICKS(SOF_T)) u0 (
        .clk(clk), .rst(rst), .tick_us(tick), .vbus_sense(vbus),
        .pwr_ovr_en(ovr_en), .pwr_ovr_val(ovr_val), .line_se0(se0),
        .line_idle(idle), .line_activity(act), .sof_valid(sof),
        .sof_frame(sof_fr), .addr_wr(awr), .addr_wdata(awd),
        .sense_raw(sense_raw), .link_state(link_state), .frame_num(frame_num),
        .host_lost(host_lost), .dev_addr(dev_addr),
        .ev_connect(ev_con), .ev_disconnect(ev_dis), .ev_link_reset(ev_rst),
        .ev_suspend(ev_sus), .ev_resume(ev_res), .ev_frame(ev_frm),
        .ev_host_lost(ev_hl)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [6:0]  ev;
        logic [2:0]  st;
        logic        hl;
        logic [10:0] fr;
        logic [6:0]  ad;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails = 0;
    logic [10:0] m_frame = '0;
    logic [6:0]  m_addr = '0;
    bit done = 0;

    task automatic step();
        @(posedge clk);
        #2;
        tick = 1'b0; act = 1'b0; sof = 1'b0; awr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            step();
        end
    endtask

    task automatic push(logic [6:0] ev, logic [2:0] st, logic hl, string req);
        item_t it;
        it.ev = ev; it.st = st; it.hl = hl; it.fr = m_frame; it.ad = m_addr; it.req = req;
        q.push_back(it);
    endtask

    task automatic check(string req, logic [2:0] st, logic hl);
        @(negedge clk);
        checks++;
        if (link_state !== st || host_lost !== hl || frame_num !== m_frame || dev_addr !== m_addr) begin
            fails++;
            $display("FAIL %s: state=%0d hl=%0b frame=%h addr=%h expected state=%0d hl=%0b frame=%h addr=%h",
                     req, link_state, host_lost, frame_num, dev_addr, st, hl, m_frame, m_addr);
        end
    endtask

    task automatic check_raw(string req, logic exp);
        checks++;
        if (sense_raw !== exp) begin
            fails++;
            $display("FAIL %s: sense_raw=%0b expected %0b", req, sense_raw, exp);
        end
    endtask

    // Monitor: every event vector is matched against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst) begin
            automatic logic [6:0] evv = {ev_con, ev_dis, ev_rst, ev_sus, ev_res, ev_frm, ev_hl};
            if (evv != 7'b0) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected event: ev=%b expected none", evv);
                end else begin
                    automatic item_t it = q.pop_front();
                    if (evv !== it.ev || link_state !== it.st || host_lost !== it.hl ||
                        frame_num !== it.fr || dev_addr !== it.ad) begin
                        fails++;
                        $display("FAIL %s: ev=%b st=%0d hl=%0b fr=%h ad=%h expected ev=%b st=%0d hl=%0b fr=%h ad=%h",
                                 it.req, evv, link_state, host_lost, frame_num, dev_addr,
                                 it.ev, it.st, it.hl, it.fr, it.ad);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1: reset state
        check("R1", 3'd0, 1'b0);
        check_raw("R1", 1'b0);

        // R2: connect
        vbus = 1'b1;
        push(E_CON, 3'd1, 1'b0, "R2");
        step();
        check("R2", 3'd1, 1'b0);

        // R11: address write
        awr = 1'b1; awd = 7'h2A; m_addr = 7'h2A;
        step();
        check("R11", 3'd1, 1'b0);

        // R6: activity restarts idle count, then powered suspends to 2
        idle = 1'b1;
        ticks(IDLE_T - 1);
        act = 1'b1;
        step();
        check("R6", 3'd1, 1'b0);
        push(E_SUS, 3'd2, 1'b0, "R6");
        ticks(IDLE_T);
        check("R6", 3'd2, 1'b0);

        // R7: activity in state 2 returns to 1 with no event
        act = 1'b1; idle = 1'b0;
        step();
        check("R7", 3'd1, 1'b0);

        // R5: SE0 bus reset, once per episode; R11 address cleared
        se0 = 1'b1;
        m_addr = 7'h00;
        push(E_RST, 3'd5, 1'b0, "R5");
        ticks(SE0_T);
        ticks(4);
        check("R5", 3'd5, 1'b0);
        se0 = 1'b0;
        step();

        // R8: start-of-frame moves 5 to 3
        m_frame = 11'h123;
        push(E_FRM, 3'd3, 1'b0, "R8");
        sof = 1'b1; sof_fr = 11'h123;
        step();
        check("R8", 3'd3, 1'b0);

        // R9: host lost after SOF_T ticks, cleared by next SOF
        ticks(SOF_T - 1);
        check("R9", 3'd3, 1'b0);
        push(E_HL, 3'd3, 1'b1, "R9");
        ticks(1);
        check("R9", 3'd3, 1'b1);
        m_frame = 11'h124;
        push(E_FRM, 3'd3, 1'b0, "R9");
        sof = 1'b1; sof_fr = 11'h124;
        step();
        check("R9", 3'd3, 1'b0);

        // R10: SOF coinciding with the final tick wins
        ticks(SOF_T - 1);
        m_frame = 11'h125;
        push(E_FRM, 3'd3, 1'b0, "R10");
        tick = 1'b1; sof = 1'b1; sof_fr = 11'h125;
        step();
        step();
        check("R10", 3'd3, 1'b0);
        ticks(3);
        check("R10", 3'd3, 1'b0);

        // R6: active suspends to 4
        idle = 1'b1;
        push(E_SUS, 3'd4, 1'b0, "R6");
        ticks(IDLE_T);
        check("R6", 3'd4, 1'b0);

        // R7: resume from 4
        act = 1'b1; idle = 1'b0;
        push(E_RES, 3'd3, 1'b0, "R7");
        step();
        check("R7", 3'd3, 1'b0);

        // R11: bus reset beats a same-cycle address write
        awr = 1'b1; awd = 7'h11; m_addr = 7'h11;
        step();
        check("R11", 3'd3, 1'b0);
        se0 = 1'b1;
        ticks(SE0_T - 1);
        m_addr = 7'h00;
        push(E_RST, 3'd5, 1'b0, "R11");
        tick = 1'b1; awr = 1'b1; awd = 7'h55;
        step();
        step();
        check("R11", 3'd5, 1'b0);
        se0 = 1'b0;
        step();

        // R12: power loss beats a same-cycle completed SE0 count
        awr = 1'b1; awd = 7'h33; m_addr = 7'h33;
        step();
        se0 = 1'b1;
        ticks(SE0_T - 1);
        push(E_DIS, 3'd0, 1'b0, "R12");
        tick = 1'b1; vbus = 1'b0;
        step();
        step();
        check("R12", 3'd0, 1'b0);
        se0 = 1'b0;
        step();

        // R4: override replaces the pin; raw pin still visible
        ovr_en = 1'b1; ovr_val = 1'b1;
        push(E_CON, 3'd1, 1'b0, "R4");
        step();
        check("R4", 3'd1, 1'b0);
        check_raw("R4", 1'b0);
        ovr_val = 1'b0; vbus = 1'b1;
        push(E_DIS, 3'd0, 1'b0, "R4");
        step();
        check("R4", 3'd0, 1'b0);
        check_raw("R4", 1'b1);
        ovr_en = 1'b0;
        push(E_CON, 3'd1, 1'b0, "R4");
        step();
        check("R4", 3'd1, 1'b0);

        // R3: disconnect from powered
        vbus = 1'b0;
        push(E_DIS, 3'd0, 1'b0, "R3");
        step();
        check("R3", 3'd0, 1'b0);

        repeat (3) step();
        while (q.size() != 0) begin
            automatic item_t it = q.pop_front();
            checks++;
            fails++;
            $display("FAIL %s: event never seen, expected ev=%b", it.req, it.ev);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule